// File: doc/BRIEF.md
# Phase Lock Alarm Supervisor

This block supervises how long a phase-locked loop takes to lock onto the reference input that is currently selected. It counts one-second timebase ticks while the loop is unlocked. If the programmed period runs out before lock is reported, it sets a sticky alarm bit for that input. There is one alarm bit for each of up to fourteen inputs. The alarm vector is also driven out as a disqualification vector, so the reference selector stops using any input that has failed.

The period is a 6-bit value scaled by a power-of-two factor that a 2-bit code selects. Alarms are cleared in one of two ways, chosen by a mode input. In write-clear mode, software writes 1 to a bit. In auto-clear mode, each alarm has its own countdown and expires one period after it was raised. The lock timer is a four-state machine:

- `ST_IDLE`: no valid target.
- `ST_TIMING`: counting ticks while unlocked.
- `ST_LOCKED`: lock present, count held.
- `ST_BARRED`: the selected input is alarmed and is not timed.

Its transitions are:

- Any state goes to IDLE on a selection change, an out-of-range index or a zero timeout value.
- Any state goes to BARRED when the selected input is alarmed.
- IDLE goes to LOCKED or TIMING, depending on lock.
- TIMING goes to LOCKED on lock.
- TIMING goes to BARRED on expiry, raising the alarm.
- LOCKED goes to TIMING on loss of lock, restarting from zero.
- BARRED goes to IDLE once the alarm clears.

Top module: `lock_alarm_sup`

## Requirements
- R1: The timeout period in ticks is `to_val` multiplied by 1, 2, 4 or 8 for `to_mul` codes 00, 01, 10 and 11.
- R2: Input k is selected with `sel_idx` = k, for k from 1 to 14. Alarm bit k-1 sets on the clock edge that samples the tick completing the period, provided that input stayed selected and unlocked for the whole period. Index 0 and index 15 select nothing and raise no alarm.
- R3: The lock timer holds while `lock_in` is high, and no alarm is raised then. It restarts from zero when lock is lost or when `sel_idx` changes.
- R4: A `to_val` of zero raises no alarm, however many ticks arrive.
- R5: When `auto_clr` is 0, an edge with `wr_en` high clears every alarm bit whose `wr_data` bit is 1. Bits written with 0 keep their value.
- R6: When `auto_clr` is 1, writes have no effect. Each alarm clears on the tick that completes one period counted from the tick after it was raised, and each bit is timed independently of the others.
- R7: `disq_o` equals the alarm vector in every cycle. An alarmed input that stays selected is not timed again, and it keeps its alarm until that alarm is cleared.
- R8: A synchronous reset clears all alarms, the disqualification vector and all timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_idx | input | 4 | Selected input number, 1..14 valid |
| lock_in | input | 1 | Loop lock indication |
| tick_1s | input | 1 | One-cycle pulse once per second |
| to_val | input | 6 | Timeout value in seconds |
| to_mul | input | 2 | Timeout multiplier code |
| auto_clr | input | 1 | 1 = auto-clear, 0 = write-1-to-clear |
| wr_en | input | 1 | Alarm register write strobe |
| wr_data | input | 14 | Write data, bit k-1 for input k |
| alarm_o | output | 14 | Sticky alarm bits, bit k-1 for input k |
| disq_o | output | 14 | Disqualification vector to the selector |

## Verification
Raising an alarm, clearing it by a write and clearing it by auto-expiry all take effect on the same clock edge that samples the enabling tick or write. All three are therefore visible one cycle after the stimulus is driven. A new selection needs two edges before timing starts: one to register the change and one to leave IDLE. The bench drives inputs on falling edges and waits three cycles after every selection change. It then pushes the expected alarm vector into the scoreboard only at the falling edge after the last tick or write, and compares the alarm and disqualification outputs there.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TIMING = 2'd1,
        ST_LOCKED = 2'd2,
        ST_BARRED = 2'd3
    } lpa_state_e;
endpackage

// File: rtl/lpa_period.sv
module lpa_period #(
    parameter int TO_W  = 6,
    parameter int MUL_W = 2,
    localparam int PER_W = TO_W + (1 << MUL_W) - 1
) (
    input  logic [TO_W-1:0]  to_val,
    input  logic [MUL_W-1:0] to_mul,
    output logic [PER_W-1:0] period
);
    // factor is 2**code: the multiplier is a left shift
    always_comb begin
        period = PER_W'(to_val) << to_mul;
    end
endmodule

// File: rtl/lpa_lock_fsm.sv
module lpa_lock_fsm
    import lpa_pkg::*;
#(
    parameter int N_IN  = 14,
    parameter int SEL_W = 4,
    parameter int PER_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_idx,
    input  logic             lock_in,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    input  logic [N_IN-1:0]  alarm_vec,
    output logic [N_IN-1:0]  raise_vec
);
    lpa_state_e       st_q, st_d;
    logic [SEL_W-1:0] sel_q;
    logic [PER_W-1:0] cnt_q, cnt_d;
    logic [N_IN-1:0]  sel_oh;
    logic             sel_ok, sel_chg, alarm_sel, raise;
    logic [PER_W:0]   cnt_inc;

    // decode the selected input into a one-hot vector
    always_comb begin
        sel_oh = '0;
        for (int k = 0; k < N_IN; k++) begin
            if (sel_idx == SEL_W'(k + 1)) sel_oh[k] = 1'b1;
        end
    end

    assign sel_ok    = |sel_oh;
    assign sel_chg   = (sel_idx != sel_q);
    assign alarm_sel = |(sel_oh & alarm_vec);
    assign cnt_inc   = {1'b0, cnt_q} + 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            sel_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            sel_q <= sel_idx;
        end
    end

    // next state and outputs
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        raise = 1'b0;
        if (sel_chg || !sel_ok || (period == '0)) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else if (alarm_sel) begin
            st_d  = ST_BARRED;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d  = lock_in ? ST_LOCKED : ST_TIMING;
                    cnt_d = '0;
                end
                ST_TIMING: begin
                    if (lock_in) begin
                        st_d  = ST_LOCKED;
                        cnt_d = '0;
                    end else if (tick) begin
                        if (cnt_inc >= {1'b0, period}) begin
                            raise = 1'b1;
                            st_d  = ST_BARRED;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_inc[PER_W-1:0];
                        end
                    end
                end
                ST_LOCKED: begin
                    if (!lock_in) begin
                        st_d  = ST_TIMING;
                        cnt_d = '0;
                    end
                end
                ST_BARRED: begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end
                default: begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    assign raise_vec = raise ? sel_oh : '0;
endmodule

// File: rtl/lpa_alarm_slot.sv
module lpa_alarm_slot #(
    parameter int PER_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raise,
    input  logic             auto_mode,
    input  logic             wr_clr,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic             alarm
);
    logic [PER_W-1:0] age_q;
    logic [PER_W:0]   age_inc;

    assign age_inc = {1'b0, age_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm <= 1'b0;
            age_q <= '0;
        end else if (raise) begin
            alarm <= 1'b1;
            age_q <= '0;
        end else if (!alarm) begin
            age_q <= '0;
        end else if (auto_mode) begin
            if (tick) begin
                if (age_inc >= {1'b0, period}) begin
                    alarm <= 1'b0;
                    age_q <= '0;
                end else begin
                    age_q <= age_inc[PER_W-1:0];
                end
            end
        end else begin
            age_q <= '0;
            if (wr_clr) alarm <= 1'b0;
        end
    end
endmodule

// File: rtl/lock_alarm_sup.sv
module lock_alarm_sup #(
    parameter int N_IN  = 14,
    parameter int SEL_W = 4,
    parameter int TO_W  = 6,
    parameter int MUL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_idx,
    input  logic             lock_in,
    input  logic             tick_1s,
    input  logic [TO_W-1:0]  to_val,
    input  logic [MUL_W-1:0] to_mul,
    input  logic             auto_clr,
    input  logic             wr_en,
    input  logic [N_IN-1:0]  wr_data,
    output logic [N_IN-1:0]  alarm_o,
    output logic [N_IN-1:0]  disq_o
);
    localparam int PER_W = TO_W + (1 << MUL_W) - 1;

    logic [PER_W-1:0] period;
    logic [N_IN-1:0]  raise_vec;
    logic [N_IN-1:0]  alarm_q;

    lpa_period #(.TO_W(TO_W), .MUL_W(MUL_W)) u_period (
        .to_val (to_val),
        .to_mul (to_mul),
        .period (period)
    );

    lpa_lock_fsm #(.N_IN(N_IN), .SEL_W(SEL_W), .PER_W(PER_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sel_idx   (sel_idx),
        .lock_in   (lock_in),
        .tick      (tick_1s),
        .period    (period),
        .alarm_vec (alarm_q),
        .raise_vec (raise_vec)
    );

    for (genvar k = 0; k < N_IN; k++) begin : g_slot
        lpa_alarm_slot #(.PER_W(PER_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .raise     (raise_vec[k]),
            .auto_mode (auto_clr),
            .wr_clr    (wr_en & wr_data[k]),
            .tick      (tick_1s),
            .period    (period),
            .alarm     (alarm_q[k])
        );
    end

    assign alarm_o = alarm_q;
    assign disq_o  = alarm_q;
endmodule

// File: rtl/lpa_checker.sv
module lpa_checker #(
    parameter int N_IN  = 14,
    parameter int SEL_W = 4,
    parameter int TO_W  = 6,
    parameter int MUL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] sel_idx,
    input logic             lock_in,
    input logic             tick_1s,
    input logic [TO_W-1:0]  to_val,
    input logic             auto_clr,
    input logic             wr_en,
    input logic [N_IN-1:0]  wr_data,
    input logic [N_IN-1:0]  alarm_o,
    input logic [N_IN-1:0]  disq_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (alarm_o == '0)); // R8
    AST_RAISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        ((alarm_o & ~$past(alarm_o)) != '0) |-> $past(tick_1s)); // R2
    AST_ONE_RAISE: assert property (@(posedge clk) disable iff (rst)
        $countones(alarm_o & ~$past(alarm_o)) <= 1); // R2
    AST_NO_RAISE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        $past(lock_in) |-> ((alarm_o & ~$past(alarm_o)) == '0)); // R3
    AST_NO_RAISE_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(to_val) == '0) |-> ((alarm_o & ~$past(alarm_o)) == '0)); // R4
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(auto_clr)) |-> ((alarm_o & $past(wr_data & alarm_o)) == '0)); // R5
    AST_AUTO_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        ($past(auto_clr) && ((~alarm_o & $past(alarm_o)) != '0)) |-> $past(tick_1s)); // R6
    AST_DISQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (disq_o == alarm_o)); // R7
endmodule

bind lock_alarm_sup lpa_checker #(
    .N_IN(N_IN), .SEL_W(SEL_W), .TO_W(TO_W), .MUL_W(MUL_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_idx  (sel_idx),
    .lock_in  (lock_in),
    .tick_1s  (tick_1s),
    .to_val   (to_val),
    .auto_clr (auto_clr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .alarm_o  (alarm_o),
    .disq_o   (disq_o)
);

// File: tb/sim_lock_alarm_sup.sv
module sim_lock_alarm_sup;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  sel_idx = '0;
    logic        lock_in = 1'b0;
    logic        tick_1s = 1'b0;
    logic [5:0]  to_val = '0;
    logic [1:0]  to_mul = '0;
    logic        auto_clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [13:0] wr_data = '0;
    logic [13:0] alarm_o, disq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [13:0] al;
        string       tag;
    } exp_t;
    exp_t sbq[$];
    event chk_ev;

    always #2 clk = ~clk;

    lock_alarm_sup u0 (
        .clk(clk), .rst(rst), .sel_idx(sel_idx), .lock_in(lock_in),
        .tick_1s(tick_1s), .to_val(to_val), .to_mul(to_mul),
        .auto_clr(auto_clr), .wr_en(wr_en), .wr_data(wr_data),
        .alarm_o(alarm_o), .disq_o(disq_o)
    );

    // monitor: compare outputs against queued expectations
    initial begin
        forever begin
            @(chk_ev);
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                if (alarm_o !== e.al || disq_o !== e.al) begin
                    errors++;
                    $display("FAIL %s: alarm=%h disq=%h expected=%h",
                             e.tag, alarm_o, disq_o, e.al);
                end
            end
        end
    end

    task automatic expect_al(input logic [13:0] al, input string tag);
        exp_t e;
        e.al = al;
        e.tag = tag;
        sbq.push_back(e);
        -> chk_ev;
        #0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1s = 1'b1;
            @(negedge clk);
            tick_1s = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic select(input logic [3:0] s);
        sel_idx = s;
        cyc(3);
    endtask

    task automatic write(input logic [13:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        expect_al(14'h0000, "R8 reset state");

        // R1/R2: period 3 on input 3
        to_val = 6'd3; to_mul = 2'b00;
        select(4'd3);
        ticks(2);
        expect_al(14'h0000, "R2 no alarm before period");
        ticks(1);
        expect_al(14'h0004, "R2 alarm on input 3 at period");
        ticks(3);
        expect_al(14'h0004, "R7 barred input not retimed");

        // R5: write 0 keeps, write 1 clears
        select(4'd0);
        write(14'h3FFB);
        expect_al(14'h0004, "R5 write 0 keeps alarm");
        write(14'h0004);
        expect_al(14'h0000, "R5 write 1 clears alarm");

        // R1: multiplier code 10 -> factor 4
        to_val = 6'd1; to_mul = 2'b10;
        select(4'd5);
        ticks(3);
        expect_al(14'h0000, "R1 x4 not yet expired");
        ticks(1);
        expect_al(14'h0010, "R1 x4 expires on 4th tick");

        // R3: hold while locked, restart on lock loss
        to_val = 6'd2; to_mul = 2'b00;
        lock_in = 1'b1;
        select(4'd7);
        ticks(5);
        expect_al(14'h0010, "R3 no alarm while locked");
        lock_in = 1'b0;
        cyc(1);
        ticks(1);
        expect_al(14'h0010, "R3 restart after lock loss");
        ticks(1);
        expect_al(14'h0050, "R3 alarm after restart period");

        // R3: selection change restarts
        select(4'd0);
        write(14'h3FFF);
        to_val = 6'd3;
        select(4'd9);
        ticks(2);
        select(4'd10);
        ticks(2);
        expect_al(14'h0000, "R3 selection change restarts");
        ticks(1);
        expect_al(14'h0200, "R3 alarm on input 10");

        // R4: zero timeout, R2: invalid index
        to_val = 6'd0;
        select(4'd11);
        ticks(10);
        expect_al(14'h0200, "R4 zero timeout disables");
        to_val = 6'd3;
        select(4'd15);
        ticks(5);
        expect_al(14'h0200, "R2 index 15 selects nothing");
        select(4'd0);

        // R6: auto-clear mode
        auto_clr = 1'b1;
        write(14'h0200);
        expect_al(14'h0200, "R6 write ignored in auto mode");
        select(4'd12);
        ticks(2);
        expect_al(14'h0200, "R6 auto alarm held before period");
        ticks(1);
        expect_al(14'h0800, "R6 input 10 expires, input 12 raised");
        select(4'd0);
        ticks(2);
        expect_al(14'h0800, "R6 independent countdown held");
        ticks(1);
        expect_al(14'h0000, "R6 input 12 expires");

        // R8: reset clears a live alarm
        auto_clr = 1'b0;
        to_val = 6'd1;
        select(4'd2);
        ticks(1);
        expect_al(14'h0002, "R2 period 1 on input 2");
        rst = 1'b1;
        cyc(1);
        rst = 1'b0;
        cyc(1);
        expect_al(14'h0000, "R8 reset clears alarm");

        cyc(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int n = 0; n < 20000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule